// File: doc/BRIEF.md
# Cycle Watchdog with Keyed Unlock

This block guards a small processor against runaway software. It sits on the processor's register write port and watches for writes to a single write-only service register. After any hardware reset the guard is dormant. Software wakes it by writing a first key byte and then a second key byte to that register. From then on a 14-bit counter advances on every machine cycle, and software must repeat the same two-byte key before the counter runs out. If the counter runs out, the block drives a reset pulse of fixed length out to the rest of the chip.

Once awake, software cannot put the guard back to sleep. Only the external hardware reset or the block's own reset pulse returns it to the dormant state. The counter value is never visible at the port and cannot be loaded by software. Machine-cycle timing comes from a one-clock-wide tick input, so the block runs on the fast system clock without a clock of its own.

Top module: `cycle_watchdog`

## Requirements
- R1: After the synchronous reset `rst` the guard is dormant and `rst_out` is 0. Machine-cycle ticks alone never produce a pulse.
- R2: The guard wakes when a write of 0x1E to address 0xA6 is followed by a write of 0xE1 to address 0xA6, with no other write to 0xA6 between them. The counter then starts from zero.
- R3: When the guard is awake, the counter advances by one on every clock edge where `cycle_tick` is 1. A tick that arrives while the count is 0x3FFF is an overflow, and `rst_out` goes to 1 on that same edge. With ticks on every clock, `rst_out` rises 16385 clocks after the edge that takes the 0xE1 write.
- R4: When the guard is awake, the same 0x1E then 0xE1 pair clears the counter to zero. This is the service operation, and the next overflow is then timed from the service.
- R5: Any write to 0xA6 that directly follows 0x1E and is not 0xE1 abandons the partial key, and so does a lone 0xE1. A fresh 0x1E starts the key again.
- R6: Writes to addresses other than 0xA6 do not break a partial key and have no other effect.
- R7: An overflow holds `rst_out` at 1 for exactly PULSE_CLKS clocks (default 96).
- R8: Software cannot put the guard to sleep. Writes of any value other than a completed key do not stop or delay the next overflow.
- R9: The reset pulse puts the guard back to sleep and clears the counter and any partial key. No further pulse comes until the key is written again.
- R10: The hardware reset `rst` ends a pulse that is in progress and puts the guard to sleep.
- R11: Clock edges where `cycle_tick` is 0 do not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| cycle_tick | input | 1 | One-clock machine-cycle enable |
| rst_out | output | 1 | Active-high reset pulse, registered |

## Verification
The hardest situation to reach from the ports is the exact overflow edge. Getting there takes 16384 machine cycles after the key, and the timing must be shown to restart both on a service and when ticks are gated. The stimulus keeps ticks running, writes the key in several interleavings (bad second byte, a lone second byte, writes to other addresses placed between the two bytes), and then measures the clocks from the key to the rising edge of the pulse. A cycle-accurate behavioural model in the bench follows every write and tick, so that a single-cycle slip in the key latency or in the overflow edge shows up as a mismatch.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_t;
endpackage

// File: rtl/wdg_keyseq.sv
module wdg_keyseq #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              svc_o
);
  import wdg_pkg::*;

  seq_state_t state_q;
  logic       reg_hit;
  logic       svc_q;

  assign reg_hit = wr_en_i && (wr_addr_i == REG_ADDR);

  // A write to the service register always decides the next key state;
  // writes elsewhere leave a partial key untouched.
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      state_q <= SEQ_IDLE;
      svc_q   <= 1'b0;
    end else begin
      svc_q <= reg_hit && (state_q == SEQ_ARMED) && (wr_data_i == KEY_SECOND);
      if (reg_hit)
        state_q <= (wr_data_i == KEY_FIRST) ? SEQ_ARMED : SEQ_IDLE;
    end
  end

  assign svc_o = svc_q;

  // R2 / R4: a key completion follows a second-key write to the register
  assert_key_source_R2: assert property (@(posedge clk) disable iff (rst)
    svc_o |-> $past(reg_hit && (wr_data_i == KEY_SECOND)));

  // R6: foreign-address writes keep an armed partial key armed
  assert_foreign_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_ARMED && !reg_hit && !clr_i) |=> (state_q == SEQ_ARMED));
endmodule

// File: rtl/wdg_cycle_cnt.sv
module wdg_cycle_cnt #(
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic svc_i,
  input  logic tick_i,
  output logic ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (svc_i) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (en_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ovf_o = en_q && tick_i && !svc_i && !clr_i && (cnt_q == CNT_MAX);

  // R1: a dormant guard holds a zero count
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (cnt_q == '0));

  // R8: nothing but the clear path can drop the enable
  assert_no_sw_disable_R8: assert property (@(posedge clk) disable iff (rst)
    (en_q && !clr_i) |=> en_q);

  // R4: service leaves an awake, zeroed counter
  assert_service_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (svc_i && !clr_i) |=> (en_q && cnt_q == '0));

  // R11: a gated edge leaves the count unchanged
  assert_gated_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !svc_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int PULSE_CLKS = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int PW = $clog2(PULSE_CLKS + 1);
  localparam logic [PW-1:0] LOAD = PW'(PULSE_CLKS - 1);

  logic [PW-1:0] rem_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      out_q <= 1'b0;
    end else if (fire_i) begin
      rem_q <= LOAD;
      out_q <= 1'b1;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end else begin
      out_q <= 1'b0;
    end
  end

  assign pulse_o = out_q;

  // R3: a pulse only starts from an overflow
  assert_start_from_ovf_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(fire_i));

  // R10: hardware reset ends any pulse
  assert_hw_reset_ends_R10: assert property (@(posedge clk)
    rst |=> !pulse_o);
endmodule

// File: rtl/cycle_watchdog.sv
module cycle_watchdog #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 14,
  parameter int PULSE_CLKS = 96,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cycle_tick,
  output logic              rst_out
);
  logic svc;
  logic ovf;
  logic pulse;

  // the outgoing pulse resets this block as it resets the rest of the chip
  wdg_keyseq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_keyseq (
    .clk(clk), .rst(rst), .clr_i(pulse),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .svc_o(svc)
  );

  wdg_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(pulse), .svc_i(svc),
    .tick_i(cycle_tick), .ovf_o(ovf)
  );

  wdg_pulse #(.PULSE_CLKS(PULSE_CLKS)) u_pulse (
    .clk(clk), .rst(rst), .fire_i(ovf), .pulse_o(pulse)
  );

  assign rst_out = pulse;

  // R9: no second overflow while a pulse is running
  assert_no_refire_R9: assert property (@(posedge clk) disable iff (rst)
    pulse |-> !ovf);
endmodule

// File: tb/cycle_watchdog_bench.sv
`timescale 1ns/1ps
module cycle_watchdog_bench;
  localparam int PULSE = 96;
  localparam int WRAP  = 16384;
  localparam int LIMIT = 40000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       cycle_tick = 1'b1;
  logic       rst_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit tick_alt = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_en = 0, m_cnt = 0, m_armed = 0, m_svc = 0, m_rem = 0, m_out = 0;

  always #2.5 clk = ~clk;

  cycle_watchdog u_cycle_watchdog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cycle_tick(cycle_tick), .rst_out(rst_out)
  );

  always @(posedge clk) begin
    int n_en, n_cnt, n_armed, n_svc, n_rem, n_out, ovf;
    bit hit;
    hit = wr_en && wr_addr == 8'hA6;
    n_en = m_en; n_cnt = m_cnt; n_armed = m_armed; n_svc = 0;
    n_rem = m_rem; n_out = m_out; ovf = 0;
    if (rst || m_out) begin
      n_en = 0; n_cnt = 0; n_armed = 0; n_svc = 0;
    end else begin
      n_svc = (hit && m_armed && wr_data == 8'hE1) ? 1 : 0;
      if (hit) n_armed = (wr_data == 8'h1E) ? 1 : 0;
      if (m_svc) begin
        n_en = 1; n_cnt = 0;
      end else if (m_en && cycle_tick) begin
        if (m_cnt == WRAP - 1) ovf = 1;
        n_cnt = (m_cnt + 1) % WRAP;
      end
    end
    if (rst) begin
      n_out = 0; n_rem = 0;
    end else if (ovf) begin
      n_out = 1; n_rem = PULSE - 1;
    end else if (m_rem > 0) begin
      n_rem = m_rem - 1;
    end else begin
      n_out = 0;
    end
    m_en = n_en; m_cnt = n_cnt; m_armed = n_armed; m_svc = n_svc;
    m_rem = n_rem; m_out = n_out;
    cycles++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) check(rst_out === (m_out != 0), cur_req, int'(rst_out), m_out);
  end

  task automatic step();
    @(negedge clk);
    cycle_tick = tick_alt ? ~cycle_tick : 1'b1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step();
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!rst_out && n < LIMIT) begin step(); n++; end
  endtask

  task automatic pulse_len(output int h);
    h = 0;
    while (rst_out && h < 1000) begin step(); h++; end
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin step(); if (rst_out) seen++; end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    int n, h;
    steps(4);
    rst = 1'b0;
    step();
    cur_req = "R1";
    check(rst_out == 1'b0, "R1 reset state", int'(rst_out), 0);

    // R5: bad second byte, lone second byte; R1: ticks alone never fire
    cur_req = "R5";
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
    wr(8'hA6, 8'hE1);
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h00); wr(8'hA6, 8'hE1);
    quiet(17000, "R5 R1 no wake");

    // R2 R3 R6: key with a foreign write in between
    cur_req = "R6";
    wr(8'hA6, 8'h1E); wr(8'h80, 8'hE1); wr(8'hA7, 8'h1E); wr(8'hA6, 8'hE1);
    wait_rise(n);
    check(n == WRAP + 1, "R2 R3 R6 overflow latency", n, WRAP + 1);
    pulse_len(h);
    check(h == PULSE, "R7 pulse length", h, PULSE);

    // R9: pulse sends the guard back to sleep
    cur_req = "R9";
    quiet(17000, "R9 dormant after pulse");

    // R4: service restarts the count
    cur_req = "R4";
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    quiet(10000, "R4 before service");
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    wait_rise(n);
    check(n == WRAP + 1, "R4 latency from service", n, WRAP + 1);
    pulse_len(h);
    step();

    // R8: stray writes neither disable nor delay
    cur_req = "R8";
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    wr(8'hA6, 8'h00); wr(8'hA6, 8'hFF); wr(8'hA6, 8'h1E); wr(8'hA6, 8'h1E);
    wr(8'h20, 8'hE1); wr(8'hA6, 8'h5A);
    wait_rise(n);
    check(n == WRAP + 1 - 12, "R8 overflow not delayed", n, WRAP + 1 - 12);
    pulse_len(h);
    step();

    // R11: ticks on alternate clocks only
    cur_req = "R11";
    tick_alt = 1'b1;
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    quiet(20000, "R11 gated ticks slow the count");
    wait_rise(n);
    check(n > 0 && n < LIMIT, "R11 overflow after gated run", n, 1);
    pulse_len(h);
    tick_alt = 1'b0;
    step();

    // R10: hardware reset cuts a pulse short
    cur_req = "R10";
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    wait_rise(n);
    steps(10);
    check(rst_out == 1'b1, "R10 pulse running", int'(rst_out), 1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check(rst_out == 1'b0, "R10 pulse ended", int'(rst_out), 0);
    quiet(17000, "R10 dormant after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule